// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel Converter Code Bank

This block holds the digital codes for an array of eight 14-bit converter channels and loads them over a three-wire serial port. The port has a serial clock, a data line and a load line. While the load line is high, each rising edge of the serial clock shifts one bit into an 18-bit frame register. A frame carries a 4-bit channel address followed by a 14-bit code. When the load line falls, the code is written into the holding register of the addressed channel. At the same moment the port freezes, so toggling the serial clock or data line has no effect.

The last stage of the frame register is brought out as a serial output, together with a separate output-enable bit. Several devices can therefore be chained, and a host can read a frame back. An active-low asynchronous preset sets every channel to the offset-binary mid-scale code, which is the zero-output level. All serial pins are sampled in the system clock domain, and their edges are detected there.

Top module: `dac_serial_bank`

## Requirements
- R1: A frame is 18 bits long and is shifted most significant bit first. The first four bits form the address (A3 down to A0) and the last fourteen form the code (D13 down to D0).
- R2: Each rising edge of `serClk` seen while `frameLd` is high shifts exactly one bit. Holding `serClk` at a steady level shifts nothing.
- R3: While `frameLd` is low, `serClk` and `serIn` are ignored, and the frame register keeps its contents.
- R4: When `frameLd` is sampled high on one `clk` edge and low on the next, the frame's code is written to the channel whose address is 0 to 7. This happens at that second edge, and all other channels keep their values.
- R5: A commit whose address is 8 to 15 (A3 = 1) changes no channel.
- R6: `serOut` is the last frame-register stage. Right after the 18th shift it shows A3, and 17 further shifts present the remaining frame bits in order.
- R7: `serOutEn` is 1 while `frameLd` is high and 0 while it is low.
- R8: While `rstN` is low, every channel asynchronously holds 14'h2000 (only bit 13 set), and the frame register is cleared, so `serOut` is 0.
- R9: If `rstN` is low when a falling edge of `frameLd` is sampled, the preset wins and every channel stays at 14'h2000.
- R10: Codes are stored bit-exact in offset binary. This includes 14'h0000 (negative full scale) and 14'h3FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low preset to mid-scale |
| serClk | input | 1 | Serial shift clock, synchronous to clk |
| serIn | input | 1 | Serial data in |
| frameLd | input | 1 | High: port shifts; falling edge: commit and freeze |
| serOut | output | 1 | Last frame-register stage |
| serOutEn | output | 1 | Output enable for serOut (0 means high impedance) |
| chanCode | output | 112 | Eight 14-bit channel codes, channel n at bits [14n+13:14n] |

## Verification
The bench first walks a table of frames. The table includes addresses 8 to 15 and the two extreme codes, so a decoder that aliased A3 away would overwrite channels 0 to 7, and a datapath that converted codes would corrupt 0x0000 or 0x3FFF. A readback run checks A3 on `serOut` right after the 18th shift and then the 17 remaining bits. An off-by-one register length would shift every readback bit. Toggling the serial pins while the port is frozen, then reading the frame back, exposes a design that keeps shifting with load low. Holding `serClk` high for many cycles before a commit catches level-sensitive shifting. Dropping the load line together with the preset, and checking codes between clock edges during a preset, exposes a commit that beats the reset and a synchronous-only preset.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  // strobes from port control to datapath, one clk wide
  typedef struct packed {
    logic shiftEn;
    logic commitEn;
  } bank_strobe_t;

endpackage

// File: rtl/dac_port_ctrl.sv
module dac_port_ctrl
  import dac_bank_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         frameLd,
  output bank_strobe_t strobe
);

  logic prevSclk;
  logic prevLd;

  // prevSclk resets high so a clock already high at release is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSclk <= 1'b1;
      prevLd   <= 1'b0;
    end else begin
      prevSclk <= serClk;
      prevLd   <= frameLd;
    end
  end

  assign strobe.shiftEn  = frameLd & serClk & ~prevSclk;
  assign strobe.commitEn = prevLd & ~frameLd;

endmodule

// File: rtl/dac_bank_dp.sv
module dac_bank_dp
  import dac_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 14,
  parameter int AW  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  bank_strobe_t        strobe,
  input  logic                serIn,
  output logic [AW+CW-1:0]    frameWord,
  output logic [NCH*CW-1:0]   chanCode
);

  localparam int FW = AW + CW;
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  logic [AW-1:0] frameAddr;
  logic [CW-1:0] frameCode;

  assign frameAddr = frameWord[FW-1 -: AW];
  assign frameCode = frameWord[CW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      frameWord <= '0;
    else if (strobe.shiftEn)
      frameWord <= {frameWord[FW-2:0], serIn};
  end

  // addresses at or above NCH match no channel and are dropped
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic hit;
    assign hit = strobe.commitEn && (frameAddr == AW'(ch));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        chanCode[ch*CW +: CW] <= MID;
      else if (hit)
        chanCode[ch*CW +: CW] <= frameCode;
    end
  end

endmodule

// File: rtl/dac_serial_bank.sv
module dac_serial_bank
  import dac_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 14,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serIn,
  input  logic              frameLd,
  output logic              serOut,
  output logic              serOutEn,
  output logic [NCH*CW-1:0] chanCode
);

  localparam int FW = AW + CW;

  bank_strobe_t   strobe;
  logic [FW-1:0]  frameWord;

  dac_port_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .frameLd (frameLd),
    .strobe  (strobe)
  );

  dac_bank_dp #(.NCH(NCH), .CW(CW), .AW(AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .serIn     (serIn),
    .frameWord (frameWord),
    .chanCode  (chanCode)
  );

  assign serOut   = frameWord[FW-1];
  assign serOutEn = frameLd;

endmodule

// File: rtl/dac_serial_bank_chk.sv
module dac_serial_bank_chk #(
  parameter int NCH = 8,
  parameter int CW  = 14,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              serClk,
  input logic              frameLd,
  input logic [AW+CW-1:0]  frameWord,
  input logic [NCH*CW-1:0] chanCode
);

  localparam int FW = AW + CW;
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  logic          pLd;
  logic          pSclk;
  logic [AW-1:0] lastAddr;
  logic [CW-1:0] lastCode;
  logic          commitNow;
  logic          edgeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pLd      <= 1'b0;
      pSclk    <= 1'b1;
      lastAddr <= '0;
      lastCode <= '0;
    end else begin
      pLd      <= frameLd;
      pSclk    <= serClk;
      lastAddr <= frameWord[FW-1 -: AW];
      lastCode <= frameWord[CW-1:0];
    end
  end

  assign commitNow = pLd && !frameLd;
  assign edgeNow   = frameLd && serClk && !pSclk;

  function automatic logic [CW-1:0] pick(input logic [NCH*CW-1:0] v,
                                         input logic [AW-1:0] a);
    pick = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (a == AW'(ch)) pick = v[ch*CW +: CW];
  endfunction

  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !edgeNow |=> $stable(frameWord));  // R2

  AST_PORT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !frameLd |=> $stable(frameWord));  // R3

  AST_NO_LOAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !commitNow |=> $stable(chanCode));  // R4

  AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (commitNow && int'(frameWord[FW-1 -: AW]) < NCH)
      |=> pick(chanCode, lastAddr) == lastCode);  // R4

  AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (commitNow && int'(frameWord[FW-1 -: AW]) >= NCH) |=> $stable(chanCode));  // R5

  AST_RESET_MIDSCALE: assert property (@(posedge clk)
    !rstN |-> (chanCode == {NCH{MID}}));  // R8

endmodule

bind dac_serial_bank dac_serial_bank_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .serClk    (serClk),
  .frameLd   (frameLd),
  .frameWord (frameWord),
  .chanCode  (chanCode)
);

// File: tb/tb_dac_serial_bank.sv
module tb_dac_serial_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CW  = 14;
  localparam logic [CW-1:0] MID = 14'h2000;
  localparam int NVEC = 12;
  // {address, code}
  localparam logic [17:0] VEC [NVEC] = '{
    {4'd0,  14'h0000}, {4'd7,  14'h3FFF}, {4'd3,  14'h1555}, {4'd9,  14'h0ABC},
    {4'd5,  14'h2AAA}, {4'd15, 14'h3FFF}, {4'd1,  14'h2001}, {4'd8,  14'h0001},
    {4'd6,  14'h1FFF}, {4'd2,  14'h0F0F}, {4'd4,  14'h3003}, {4'd12, 14'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic serClk = 1'b0;
  logic serIn = 1'b0;
  logic frameLd = 1'b0;
  logic serOut;
  logic serOutEn;
  logic [NCH*CW-1:0] chanCode;

  int total = 0;
  int bad = 0;
  logic [CW-1:0] model [NCH];

  dac_serial_bank dut (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serIn    (serIn),
    .frameLd  (frameLd),
    .serOut   (serOut),
    .serOutEn (serOutEn),
    .chanCode (chanCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    for (int ch = 0; ch < NCH; ch++)
      chk(req, 32'(chanCode[ch*CW +: CW]), 32'(model[ch]));
  endtask

  task automatic shiftBit(input logic b);
    serClk = 1'b0;
    serIn  = b;
    tick(2);
    serClk = 1'b1;
    tick(2);
  endtask

  task automatic sendFrame(input logic [17:0] f);
    frameLd = 1'b1;
    tick(2);
    for (int i = 17; i >= 0; i--) shiftBit(f[i]);
  endtask

  task automatic commitFrame();
    frameLd = 1'b0;
    tick(3);
  endtask

  task automatic applyFrame(input logic [17:0] f);
    sendFrame(f);
    commitFrame();
    if (f[17] == 1'b0) model[f[16:14]] = f[13:0];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] f;
    for (int ch = 0; ch < NCH; ch++) model[ch] = MID;
    #1 rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // reset state
    chkAll("R8 reset mid-scale");
    chk("R8 serOut cleared", 32'(serOut), 32'd0);
    chk("R7 oe low with ld low", 32'(serOutEn), 32'd0);

    // vector table: R1 frame order, R4 write, R5 ignored address, R10 exact codes
    for (int i = 0; i < NVEC; i++) begin
      applyFrame(VEC[i]);
      chkAll("R1 R4 R5 R10 vector");
    end

    // R6 readback: A3 right after 18th shift, then 17 more bits
    f = {4'hA, 14'h1234};
    sendFrame(f);
    chk("R7 oe high with ld high", 32'(serOutEn), 32'd1);
    chk("R6 A3 after 18th shift", 32'(serOut), 32'(f[17]));
    for (int k = 1; k < 18; k++) begin
      shiftBit(1'b0);
      chk("R6 readback bit", 32'(serOut), 32'(f[17-k]));
    end
    applyFrame({4'd4, 14'h0246});
    chkAll("R4 after readback");

    // R3: frozen port ignores serClk and serIn
    f = {4'd2, 14'h0777};
    applyFrame(f);
    chkAll("R4 write ch2");
    for (int k = 0; k < 5; k++) shiftBit(1'b1);
    chkAll("R3 channels unchanged while frozen");
    chk("R7 oe low while frozen", 32'(serOutEn), 32'd0);
    frameLd = 1'b1;
    tick(2);
    chk("R7 oe high after raise", 32'(serOutEn), 32'd1);
    chk("R3 frame kept A3", 32'(serOut), 32'(f[17]));
    for (int k = 1; k < 18; k++) begin
      shiftBit(1'b0);
      chk("R3 frame kept bit", 32'(serOut), 32'(f[17-k]));
    end
    // register now holds address 4'b1000: ignored
    commitFrame();
    chkAll("R5 leftover address 8");

    // R2: steady high serClk must not shift
    sendFrame({4'd1, 14'h0ABC});
    tick(10);
    commitFrame();
    model[1] = 14'h0ABC;
    chk("R2 no shift on level", 32'(chanCode[1*CW +: CW]), 32'h0ABC);

    // R8 asynchronous preset between clk edges
    applyFrame({4'd6, 14'h1111});
    chkAll("R4 write ch6");
    rstN = 1'b0;
    #1;
    chk("R8 async preset ch6", 32'(chanCode[6*CW +: CW]), 32'(MID));
    tick(1);
    rstN = 1'b1;
    for (int ch = 0; ch < NCH; ch++) model[ch] = MID;
    tick(2);
    chkAll("R8 all mid after preset");

    // R9: preset together with ld fall
    sendFrame({4'd3, 14'h0123});
    rstN    = 1'b0;
    frameLd = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(2);
    chkAll("R9 preset beats commit");
    chk("R8 frame cleared", 32'(serOut), 32'd0);

    // post-reset write still works
    applyFrame({4'd7, 14'h0000});
    chkAll("R10 zero code ch7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule